// File: doc/BRIEF.md
# Front-End Control Register Bank with Byte Output Formatter

This block holds the control state of an analog imaging front end: eight 9-bit registers, picked by a 3-bit address and loaded by a parallel write strobe. The configuration word at address 0 is decoded into mode controls. These controls are three-channel operation, the sampling method (correlated double sampling or sample-and-hold), the clamp bias level, sleep, the output delay request and the output width. The channel-mux word and the six per-colour gain and offset words go out unchanged, for the analog logic that uses them.

The same block places each 16-bit conversion result on an 8-bit bus. In two-byte mode the high byte goes out first and the low byte follows on the next cycle. A byte-select flag marks which byte is on the bus. In single-byte mode only the high byte goes out. Sleep blanks the bus and drops incoming results. It does not change any register.

Top module: `afe_ctl_top`

## Requirements
- R1: After reset the configuration word reads 9'h078: three-channel, correlated double sampling and high clamp bias are on, and sleep, delay and single-byte are off. Every other register reads zero, and the bus is idle (dvalid=0, dout=0).
- R2: A write to address 0 stores data bits 5..0, forces bit 6 to 1 and forces bits 8..7 to 0.
- R3: Addresses decode as follows: 1 is the mux word, 2/3/4 are the red/green/blue gain, and 5/6/7 are the red/green/blue offset. A write changes only the register it addresses, and no register changes while wr_en is low.
- R4: Configuration bits drive the outputs as follows: bit 5 drives three_ch, bit 4 cds_mode, bit 3 clamp_hi, bit 2 sleep, bit 1 out_dly and bit 0 single_byte.
- R5: In two-byte mode (bit 0 = 0), a result accepted on a clock edge puts its high byte on dout with dsel=1 and dvalid=1 after that edge. The low byte follows after the next edge, with dsel=0 and dvalid=1.
- R6: In single-byte mode, a result puts out only its high byte, with dsel=1, for one cycle.
- R7: A result offered while a low byte is waiting to go out is ignored.
- R8: While sleep is set, dout stays zero and dvalid stays low. Results and any waiting low byte are dropped. Register writes are still accepted, and all contents remain after sleep is cleared.
- R9: On any cycle with no byte to send, dvalid is 0 and dout is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 9 | Write data |
| res_valid | input | 1 | Conversion result strobe |
| res_data | input | 16 | Conversion result |
| cfg_word | output | 9 | Configuration register contents |
| three_ch | output | 1 | Three-channel operation |
| cds_mode | output | 1 | 1 = correlated double sampling, 0 = sample-and-hold |
| clamp_hi | output | 1 | 1 = high clamp bias, 0 = low |
| sleep | output | 1 | Low-power sleep |
| out_dly | output | 1 | Output delay request |
| single_byte | output | 1 | Single-byte output mode |
| mux_word | output | 9 | Channel-mux register |
| gain_r | output | 9 | Red gain |
| gain_g | output | 9 | Green gain |
| gain_b | output | 9 | Blue gain |
| offs_r | output | 9 | Red offset |
| offs_g | output | 9 | Green offset |
| offs_b | output | 9 | Blue offset |
| dout | output | 8 | Output byte |
| dsel | output | 1 | 1 = high byte, 0 = low byte |
| dvalid | output | 1 | Byte on dout is valid |

## Verification
The assertions check these properties on every cycle:
- the fixed-bit forcing on configuration writes;
- the stability of the bank when no write is strobed;
- that a waiting low byte always follows its high byte unless sleep intervenes;
- that no low byte follows a single-byte result;
- that dout is blanked during sleep and when idle.

Only the bench scenarios can show the address decode for each register, the byte values themselves, the dropping of a result that overlaps a pending low byte, and the survival of register contents across sleep.

// File: rtl/afe_ctl_pkg.sv
package afe_ctl_pkg;
    parameter int REG_W  = 9;
    parameter int ADDR_W = 3;
    parameter int RES_W  = 16;
    parameter int BYTE_W = 8;
    localparam int NREG  = 1 << ADDR_W;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CFG   = 3'd0;
    localparam logic [ADDR_W-1:0] A_MUX   = 3'd1;
    localparam logic [ADDR_W-1:0] A_GAIN0 = 3'd2;
    localparam logic [ADDR_W-1:0] A_OFFS0 = 3'd5;

    // configuration bit positions
    localparam int B_SINGLE = 0;
    localparam int B_DLY    = 1;
    localparam int B_SLEEP  = 2;
    localparam int B_CLAMP  = 3;
    localparam int B_CDS    = 4;
    localparam int B_3CH    = 5;
    localparam int B_ONE    = 6;

    localparam logic [REG_W-1:0] CFG_RST = 9'h078;

    function automatic logic [REG_W-1:0] cfg_fix(input logic [REG_W-1:0] d);
        logic [REG_W-1:0] r;
        r        = '0;
        r[5:0]   = d[5:0];
        r[B_ONE] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/afe_regbank.sv
module afe_regbank
    import afe_ctl_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ADDR_W-1:0]                wr_addr,
    input  logic [REG_W-1:0]                 wr_data,
    output logic [NREG-1:0][REG_W-1:0]       regs_o
);
    typedef struct packed {
        logic [NREG-1:0][REG_W-1:0] regs;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_addr == A_CFG) begin
                st_d.regs[A_CFG] = cfg_fix(wr_data);
            end else begin
                st_d.regs[wr_addr] = wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs        <= '0;
            st_q.regs[A_CFG] <= CFG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_o = st_q.regs;

    // R2
    cfg_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_CFG) |=> (regs_o[A_CFG] == {3'b001, $past(wr_data[5:0])}));

    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));
endmodule

// File: rtl/afe_byte_fmt.sv
module afe_byte_fmt
    import afe_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              single_i,
    input  logic              res_valid_i,
    input  logic [RES_W-1:0]  res_data_i,
    output logic [BYTE_W-1:0] dout_o,
    output logic              dsel_o,
    output logic              dvalid_o
);
    typedef struct packed {
        logic [BYTE_W-1:0] dout;
        logic              dsel;
        logic              dvalid;
        logic              pend;
        logic [BYTE_W-1:0] low;
    } fmt_t;

    fmt_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.dout   = '0;
        st_d.dsel   = 1'b0;
        st_d.dvalid = 1'b0;
        st_d.pend   = 1'b0;
        if (sleep_i) begin
            st_d.low = st_q.low;
        end else if (st_q.pend) begin
            st_d.dout   = st_q.low;
            st_d.dvalid = 1'b1;
        end else if (res_valid_i) begin
            st_d.dout   = res_data_i[RES_W-1 -: BYTE_W];
            st_d.dsel   = 1'b1;
            st_d.dvalid = 1'b1;
            st_d.pend   = !single_i;
            st_d.low    = res_data_i[BYTE_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o   = st_q.dout;
    assign dsel_o   = st_q.dsel;
    assign dvalid_o = st_q.dvalid;

    // R5
    low_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && !sleep_i) |=> (dvalid_o && !dsel_o));

    // R6
    single_no_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dvalid_o && dsel_o && !st_q.pend) |=> !(dvalid_o && !dsel_o));

    // R8
    sleep_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (!dvalid_o && dout_o == '0));

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dvalid_o |-> (dout_o == '0));
endmodule

// File: rtl/afe_ctl_top.sv
module afe_ctl_top
    import afe_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [8:0]  wr_data,
    input  logic        res_valid,
    input  logic [15:0] res_data,
    output logic [8:0]  cfg_word,
    output logic        three_ch,
    output logic        cds_mode,
    output logic        clamp_hi,
    output logic        sleep,
    output logic        out_dly,
    output logic        single_byte,
    output logic [8:0]  mux_word,
    output logic [8:0]  gain_r,
    output logic [8:0]  gain_g,
    output logic [8:0]  gain_b,
    output logic [8:0]  offs_r,
    output logic [8:0]  offs_g,
    output logic [8:0]  offs_b,
    output logic [7:0]  dout,
    output logic        dsel,
    output logic        dvalid
);
    logic [NREG-1:0][REG_W-1:0] regs;

    afe_regbank i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .regs_o  (regs)
    );

    assign cfg_word    = regs[A_CFG];
    assign three_ch    = cfg_word[B_3CH];
    assign cds_mode    = cfg_word[B_CDS];
    assign clamp_hi    = cfg_word[B_CLAMP];
    assign sleep       = cfg_word[B_SLEEP];
    assign out_dly     = cfg_word[B_DLY];
    assign single_byte = cfg_word[B_SINGLE];
    assign mux_word    = regs[A_MUX];
    assign gain_r      = regs[A_GAIN0];
    assign gain_g      = regs[A_GAIN0 + 3'd1];
    assign gain_b      = regs[A_GAIN0 + 3'd2];
    assign offs_r      = regs[A_OFFS0];
    assign offs_g      = regs[A_OFFS0 + 3'd1];
    assign offs_b      = regs[A_OFFS0 + 3'd2];

    afe_byte_fmt i_fmt (
        .clk         (clk),
        .rst_n       (rst_n),
        .sleep_i     (sleep),
        .single_i    (single_byte),
        .res_valid_i (res_valid),
        .res_data_i  (res_data),
        .dout_o      (dout),
        .dsel_o      (dsel),
        .dvalid_o    (dvalid)
    );
endmodule

// File: tb/test_afe_ctl_top.sv
`timescale 1ns/1ps
module test_afe_ctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [8:0]  wr_data = '0;
    logic        res_valid = 1'b0;
    logic [15:0] res_data = '0;
    logic [8:0]  cfg_word, mux_word, gain_r, gain_g, gain_b, offs_r, offs_g, offs_b;
    logic        three_ch, cds_mode, clamp_hi, sleep, out_dly, single_byte;
    logic [7:0]  dout;
    logic        dsel, dvalid;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    afe_ctl_top i_afe_ctl_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .res_valid(res_valid), .res_data(res_data), .cfg_word(cfg_word),
        .three_ch(three_ch), .cds_mode(cds_mode), .clamp_hi(clamp_hi), .sleep(sleep),
        .out_dly(out_dly), .single_byte(single_byte), .mux_word(mux_word),
        .gain_r(gain_r), .gain_g(gain_g), .gain_b(gain_b),
        .offs_r(offs_r), .offs_g(offs_g), .offs_b(offs_b),
        .dout(dout), .dsel(dsel), .dvalid(dvalid)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [8:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // bus word: {dvalid, dsel, dout}
    function automatic int bus();
        return {22'd0, dvalid, dsel, dout};
    endfunction

    task automatic t_reset();
        chk("R1", "cfg", cfg_word, 9'h078);
        chk("R1", "mux", mux_word, 0);
        chk("R1", "gain_b", gain_b, 0);
        chk("R1", "offs_g", offs_g, 0);
        chk("R1", "bus", bus(), 0);
        chk("R4", "decode rst", {three_ch, cds_mode, clamp_hi, sleep, out_dly, single_byte}, 6'b111000);
    endtask

    task automatic t_cfg_force();
        wr(3'd0, 9'h1FF);
        chk("R2", "cfg all ones", cfg_word, 9'h07F);
        chk("R4", "decode all", {three_ch, cds_mode, clamp_hi, sleep, out_dly, single_byte}, 6'b111111);
        wr(3'd0, 9'h000);
        chk("R2", "cfg zero", cfg_word, 9'h040);
        wr(3'd0, 9'h0A5);
        chk("R2", "cfg pattern", cfg_word, 9'h065);
        chk("R4", "decode pattern", {three_ch, cds_mode, clamp_hi, sleep, out_dly, single_byte}, 6'b100101);
        wr(3'd0, 9'h038);
        chk("R4", "decode back", {three_ch, cds_mode, clamp_hi, sleep, out_dly, single_byte}, 6'b111000);
    endtask

    task automatic t_decode();
        wr(3'd1, 9'h1A1); wr(3'd2, 9'h102); wr(3'd3, 9'h033);
        wr(3'd4, 9'h0C4); wr(3'd5, 9'h155); wr(3'd6, 9'h0E6); wr(3'd7, 9'h1F7);
        chk("R3", "mux", mux_word, 9'h1A1);
        chk("R3", "gain_r", gain_r, 9'h102);
        chk("R3", "gain_g", gain_g, 9'h033);
        chk("R3", "gain_b", gain_b, 9'h0C4);
        chk("R3", "offs_r", offs_r, 9'h155);
        chk("R3", "offs_g", offs_g, 9'h0E6);
        chk("R3", "offs_b", offs_b, 9'h1F7);
        chk("R3", "cfg untouched", cfg_word, 9'h078);
        @(negedge clk);
        wr_addr = 3'd3; wr_data = 9'h000;
        @(negedge clk);
        chk("R3", "no strobe", gain_g, 9'h033);
    endtask

    task automatic t_two_byte();
        @(negedge clk);
        res_valid = 1'b1; res_data = 16'hA55A;
        @(posedge clk); #1;
        res_valid = 1'b0;
        chk("R5", "high byte", bus(), {2'b11, 8'hA5});
        @(posedge clk); #1;
        chk("R5", "low byte", bus(), {2'b10, 8'h5A});
        @(posedge clk); #1;
        chk("R9", "idle after pair", bus(), 0);
    endtask

    task automatic t_single();
        wr(3'd0, 9'h039);
        @(negedge clk);
        res_valid = 1'b1; res_data = 16'h3CC3;
        @(posedge clk); #1;
        res_valid = 1'b0;
        chk("R6", "only high", bus(), {2'b11, 8'h3C});
        @(posedge clk); #1;
        chk("R6", "no low", bus(), 0);
        wr(3'd0, 9'h038);
    endtask

    task automatic t_overlap();
        @(negedge clk);
        res_valid = 1'b1; res_data = 16'h1234;
        @(posedge clk); #1;
        res_data = 16'hBEEF;
        chk("R5", "high first", bus(), {2'b11, 8'h12});
        @(posedge clk); #1;
        res_valid = 1'b0;
        chk("R7", "low not displaced", bus(), {2'b10, 8'h34});
        @(posedge clk); #1;
        chk("R7", "overlap ignored", bus(), 0);
    endtask

    task automatic t_sleep();
        wr(3'd0, 9'h03C);
        chk("R8", "sleep on", sleep, 1);
        @(negedge clk);
        res_valid = 1'b1; res_data = 16'hFFFF;
        @(posedge clk); #1;
        res_valid = 1'b0;
        chk("R8", "bus blank", bus(), 0);
        wr(3'd2, 9'h0AA);
        chk("R8", "write in sleep", gain_r, 9'h0AA);
        wr(3'd0, 9'h038);
        chk("R8", "kept offs_b", offs_b, 9'h1F7);
        chk("R8", "kept mux", mux_word, 9'h1A1);
        // sleep enters while a low byte waits
        @(negedge clk);
        res_valid = 1'b1; res_data = 16'h7788;
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 9'h03C;
        @(posedge clk); #1;
        res_valid = 1'b0; wr_en = 1'b0;
        chk("R5", "high before sleep", bus(), {2'b11, 8'h77});
        @(posedge clk); #1;
        chk("R8", "pending dropped", bus(), 0);
        wr(3'd0, 9'h038);
        @(posedge clk); #1;
        chk("R8", "not revived", bus(), 0);
    endtask

    initial begin
        #4000000;
        failures++; checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg_force();
        t_decode();
        t_two_byte();
        t_single();
        t_overlap();
        t_sleep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule